// File: doc/BRIEF.md
# Serial Request Frame Memory Slave

This block sits behind a UART on a two-wire half-duplex differential bus. It parses incoming request frames from the received byte stream and turns them into single-word accesses to a local memory with one cycle of read latency. It then sends the matching reply back through the UART transmitter. The line driver is switched on only while its own reply is on the wire, so other stations can talk the rest of the time.

A write request starts with 0x02, followed by a 16-bit address and a 32-bit word. A read request starts with 0x05, followed by the address. Both fields are sent most significant byte first. A write is answered with one acknowledge byte (0x06), or with a refusal byte (0x15) if the frame stalls part way through. A read is answered with 0x01, the echoed address, and then the stored word. The receiver is never disabled, so the block hears its own reply on the bus and must discard those bytes.

Top module: `frame_mem_slave`

## Requirements
- R1: While reset is asserted, `drv_en_o`, `tx_valid_o` and `mem_we_o` are low.
- R2: A write frame (0x02, address high byte, address low byte, then four data bytes from the most significant down) causes exactly one single-cycle `mem_we_o` pulse, carrying that address and word. Every other frame or byte causes none.
- R3: A complete write frame is answered with exactly one byte, 0x06.
- R4: A read frame (0x05, address high byte, address low byte) is answered with exactly seven bytes: 0x01, address high, address low, then the stored word from its most significant byte down.
- R5: The memory read is issued after the second address byte, and the reply uses data that is valid one cycle later. A read that follows a write to the same address returns the new word.
- R6: If more than `TMO_CYC` cycles pass between two bytes of a write frame, the frame is dropped without any memory write and is answered with the single byte 0x15.
- R7: A read frame that stalls for more than `TMO_CYC` cycles is dropped with no reply.
- R8: Bytes other than 0x02 and 0x05 that arrive while the block is idle are ignored. They cause no reply and no write.
- R9: Bytes received while a reply is in progress, including the block's own echo, are ignored.
- R10: `drv_en_o` is high whenever `tx_valid_o` is high or the transmitter reports busy during a reply. It falls only after `tx_busy_i` has been low following the last accepted byte, and it is low when the block is idle.
- R11: `rx_en_o` is high at all times.
- R12: Once `tx_valid_o` is raised, it stays high with `tx_byte_o` unchanged until `tx_ready_i` accepts the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | One-cycle strobe for a received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_en_o | output | 1 | Bus receiver enable, always high |
| tx_byte_o | output | 8 | Byte offered to the UART transmitter |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |
| tx_busy_i | input | 1 | Transmitter is shifting a byte, through its stop bit |
| drv_en_o | output | 1 | Bus line driver enable |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 32 | Memory write word |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Memory read word, one cycle after the address |

## Verification
The bench sends well-formed write and read frames to the lowest address, the highest address, an address never written, and a small cluster of addresses in random order. This separates byte-order faults, address and data swaps, and stale read data. Frames stalled inside the address and data fields show whether a timed-out write is refused while a timed-out read stays silent. Stray control bytes in the idle state and echoed bytes injected while a reply is going out show whether the parser wrongly starts a frame. A randomly throttled transmitter ready and busy model exposes drops of the held byte and a driver enable that is released too early.

// File: rtl/fms_pkg.sv
package fms_pkg;
  localparam logic [7:0] CH_SOH = 8'h01;
  localparam logic [7:0] CH_STX = 8'h02;
  localparam logic [7:0] CH_ENQ = 8'h05;
  localparam logic [7:0] CH_ACK = 8'h06;
  localparam logic [7:0] CH_NAK = 8'h15;

  typedef enum logic [1:0] {RPL_ACK, RPL_NAK, RPL_DATA} rpl_kind_e;

  typedef enum logic [2:0] {
    PS_IDLE, PS_ADDR, PS_DATA, PS_RD_ISSUE, PS_RD_CAPT, PS_WR_COMMIT, PS_REPLY
  } prs_state_e;

  typedef enum logic [1:0] {TS_IDLE, TS_SEND, TS_DRAIN} txs_state_e;
endpackage

// File: rtl/fms_timeout.sv
module fms_timeout #(
  parameter int TMO_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic hit_o
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i || kick_i)   cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign hit_o = run_i && (cnt_q == LIMIT);
endmodule

// File: rtl/fms_frame_rx.sv
module fms_frame_rx
  import fms_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_byte_i,
  input  logic                    tmo_hit_i,
  output logic                    tmo_run_o,
  output logic [8*ADDR_BYTES-1:0] mem_addr_o,
  output logic [8*DATA_BYTES-1:0] mem_wdata_o,
  output logic                    mem_we_o,
  output logic                    rpl_start_o,
  output rpl_kind_e               rpl_kind_o,
  input  logic                    rpl_done_i
);
  localparam int AW    = 8 * ADDR_BYTES;
  localparam int DW    = 8 * DATA_BYTES;
  localparam int MAXB  = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DATA_BYTES - 1);

  prs_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [DW-1:0]    data_q, data_d;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    wr_d        = wr_q;
    addr_d      = addr_q;
    data_d      = data_q;
    rpl_start_o = 1'b0;
    rpl_kind_o  = RPL_ACK;
    unique case (st_q)
      PS_IDLE: begin
        if (rx_valid_i) begin
          if (rx_byte_i == CH_STX) begin
            wr_d = 1'b1; cnt_d = '0; st_d = PS_ADDR;
          end else if (rx_byte_i == CH_ENQ) begin
            wr_d = 1'b0; cnt_d = '0; st_d = PS_ADDR;
          end
        end
      end
      PS_ADDR: begin
        if (tmo_hit_i) begin
          if (wr_q) begin
            rpl_start_o = 1'b1; rpl_kind_o = RPL_NAK; st_d = PS_REPLY;
          end else begin
            st_d = PS_IDLE;
          end
        end else if (rx_valid_i) begin
          addr_d = (addr_q << 8) | AW'(rx_byte_i);
          if (cnt_q == A_LAST) begin
            cnt_d = '0;
            st_d  = wr_q ? PS_DATA : PS_RD_ISSUE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PS_DATA: begin
        if (tmo_hit_i) begin
          rpl_start_o = 1'b1; rpl_kind_o = RPL_NAK; st_d = PS_REPLY;
        end else if (rx_valid_i) begin
          data_d = (data_q << 8) | DW'(rx_byte_i);
          if (cnt_q == D_LAST) st_d = PS_WR_COMMIT;
          else                 cnt_d = cnt_q + 1'b1;
        end
      end
      PS_WR_COMMIT: begin
        rpl_start_o = 1'b1; rpl_kind_o = RPL_ACK; st_d = PS_REPLY;
      end
      PS_RD_ISSUE: st_d = PS_RD_CAPT;
      PS_RD_CAPT: begin
        rpl_start_o = 1'b1; rpl_kind_o = RPL_DATA; st_d = PS_REPLY;
      end
      PS_REPLY: if (rpl_done_i) st_d = PS_IDLE;
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign tmo_run_o   = (st_q == PS_ADDR) || (st_q == PS_DATA);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign mem_we_o    = (st_q == PS_WR_COMMIT);
endmodule

// File: rtl/fms_reply_tx.sv
module fms_reply_tx
  import fms_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  rpl_kind_e               kind_i,
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  input  logic [8*DATA_BYTES-1:0] word_i,
  output logic [7:0]              tx_byte_o,
  output logic                    tx_valid_o,
  input  logic                    tx_ready_i,
  input  logic                    tx_busy_i,
  output logic                    drv_en_o,
  output logic                    done_o
);
  localparam int LEN   = 1 + ADDR_BYTES + DATA_BYTES;
  localparam int BUF_W = 8 * LEN;
  localparam int LCW   = $clog2(LEN + 1);
  localparam logic [LCW-1:0] LEN_L = LCW'(LEN);
  localparam logic [LCW-1:0] ONE_L = LCW'(1);

  txs_state_e       ts_q, ts_d;
  logic [BUF_W-1:0] buf_q, buf_d;
  logic [LCW-1:0]   left_q, left_d;

  always_comb begin
    ts_d   = ts_q;
    buf_d  = buf_q;
    left_d = left_q;
    unique case (ts_q)
      TS_IDLE: begin
        if (start_i) begin
          ts_d = TS_SEND;
          unique case (kind_i)
            RPL_DATA: begin
              buf_d  = {CH_SOH, addr_i, word_i};
              left_d = LEN_L;
            end
            RPL_NAK: begin
              buf_d  = {CH_NAK, {(BUF_W-8){1'b0}}};
              left_d = ONE_L;
            end
            default: begin
              buf_d  = {CH_ACK, {(BUF_W-8){1'b0}}};
              left_d = ONE_L;
            end
          endcase
        end
      end
      TS_SEND: begin
        if (tx_ready_i) begin
          buf_d  = buf_q << 8;
          left_d = left_q - 1'b1;
          if (left_q == ONE_L) ts_d = TS_DRAIN;
        end
      end
      TS_DRAIN: if (!tx_busy_i) ts_d = TS_IDLE;
      default: ts_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q   <= TS_IDLE;
      buf_q  <= '0;
      left_q <= '0;
    end else begin
      ts_q   <= ts_d;
      buf_q  <= buf_d;
      left_q <= left_d;
    end
  end

  assign tx_valid_o = (ts_q == TS_SEND);
  assign tx_byte_o  = buf_q[BUF_W-1 -: 8];
  assign drv_en_o   = (ts_q != TS_IDLE);
  assign done_o     = (ts_q == TS_DRAIN) && !tx_busy_i;
endmodule

// File: rtl/frame_mem_slave.sv
module frame_mem_slave
  import fms_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4,
  parameter int TMO_CYC    = 1000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_byte_i,
  output logic                    rx_en_o,
  output logic [7:0]              tx_byte_o,
  output logic                    tx_valid_o,
  input  logic                    tx_ready_i,
  input  logic                    tx_busy_i,
  output logic                    drv_en_o,
  output logic [8*ADDR_BYTES-1:0] mem_addr_o,
  output logic [8*DATA_BYTES-1:0] mem_wdata_o,
  output logic                    mem_we_o,
  input  logic [8*DATA_BYTES-1:0] mem_rdata_i
);
  logic      tmo_run, tmo_hit;
  logic      rpl_start, rpl_done;
  rpl_kind_e rpl_kind;

  assign rx_en_o = 1'b1;

  fms_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tmo_run),
    .kick_i (rx_valid_i),
    .hit_o  (tmo_hit)
  );

  fms_frame_rx #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_byte_i   (rx_byte_i),
    .tmo_hit_i   (tmo_hit),
    .tmo_run_o   (tmo_run),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .rpl_start_o (rpl_start),
    .rpl_kind_o  (rpl_kind),
    .rpl_done_i  (rpl_done)
  );

  fms_reply_tx #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (rpl_start),
    .kind_i     (rpl_kind),
    .addr_i     (mem_addr_o),
    .word_i     (mem_rdata_i),
    .tx_byte_o  (tx_byte_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_busy_i  (tx_busy_i),
    .drv_en_o   (drv_en_o),
    .done_o     (rpl_done)
  );
endmodule

// File: rtl/fms_chk.sv
module fms_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_byte_o,
  input logic       tx_busy_i,
  input logic       drv_en_o,
  input logic       mem_we_o
);
  // R12
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_byte_o));

  // R10
  drv_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> drv_en_o);

  // R10
  drv_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drv_en_o) |-> !$past(tx_busy_i) && !$past(tx_valid_o));

  // R2
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R9
  we_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !drv_en_o);
endmodule

bind frame_mem_slave fms_chk u_fms_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_byte_o  (tx_byte_o),
  .tx_busy_i  (tx_busy_i),
  .drv_en_o   (drv_en_o),
  .mem_we_o   (mem_we_o)
);

// File: tb/tb_frame_mem_slave.sv
module tb_frame_mem_slave;
  localparam int TMO = 60;
  localparam int BYTE_CYC = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_en_o, tx_valid_o, drv_en_o, mem_we_o;
  logic [7:0]  tx_byte_o;
  logic        tx_ready, tx_busy, rdy_rand;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_wdata_o, rdata;

  int total = 0, fails = 0;
  int busy_cnt, drv_viol = 0, hold_viol = 0, rxen_viol = 0, we_cnt = 0, exp_we = 0;
  logic       prev_hold;
  logic [7:0] prev_byte;
  logic [7:0] got_q[$];
  logic [31:0] mem_m [logic [15:0]];
  logic [31:0] exp_m [logic [15:0]];

  always #10 clk = ~clk;

  frame_mem_slave #(.TMO_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .rx_en_o(rx_en_o), .tx_byte_o(tx_byte_o), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready), .tx_busy_i(tx_busy), .drv_en_o(drv_en_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_rdata_i(rdata)
  );

  // memory with one cycle read latency
  always @(posedge clk) begin
    if (mem_we_o) mem_m[mem_addr_o] = mem_wdata_o;
    rdata <= mem_m.exists(mem_addr_o) ? mem_m[mem_addr_o] : 32'h0;
  end

  // transmitter model: busy from the cycle after acceptance through the stop bit
  assign tx_busy  = (busy_cnt != 0);
  assign tx_ready = !tx_busy && rdy_rand;
  always @(negedge clk) rdy_rand <= (($urandom % 4) != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt  <= 0;
      prev_hold <= 1'b0;
    end else begin
      if (tx_valid_o && tx_ready) begin
        busy_cnt <= BYTE_CYC;
        got_q.push_back(tx_byte_o);
      end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if ((tx_busy || tx_valid_o) && !drv_en_o) drv_viol++;
      if (prev_hold && (!tx_valid_o || tx_byte_o != prev_byte)) hold_viol++;
      prev_hold <= tx_valid_o && !tx_ready;
      prev_byte <= tx_byte_o;
      if (mem_we_o) we_cnt++;
      if (!rx_en_o) rxen_viol++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
    repeat ($urandom % 12) @(negedge clk);
  endtask

  task automatic check_reply(input string req, input int n, input logic [63:0] exp);
    int t = 0;
    logic [63:0] act = '0;
    while (got_q.size() < n && t < 3000) begin @(negedge clk); t++; end
    while (drv_en_o && t < 6000) begin @(negedge clk); t++; end
    repeat (30) @(negedge clk);
    foreach (got_q[i]) act = (act << 8) | 64'(got_q[i]);
    chk(got_q.size() == n && act == exp && !drv_en_o, req, act, exp);
    got_q.delete();
  endtask

  function automatic logic [31:0] exp_word(input logic [15:0] a);
    return exp_m.exists(a) ? exp_m[a] : 32'h0;
  endfunction

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    send_byte(8'h02); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(d[31:24]); send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
    exp_m[a] = d; exp_we++;
    check_reply("R3 ack", 1, 64'h06);
  endtask

  task automatic do_read(input logic [15:0] a);
    send_byte(8'h05); send_byte(a[15:8]); send_byte(a[7:0]);
    check_reply("R4 R5 R2 read reply", 7, {8'h0, 8'h01, a, exp_word(a)});
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    repeat (5) @(negedge clk);
    chk(!drv_en_o && !tx_valid_o && !mem_we_o, "R1 reset", {drv_en_o, tx_valid_o, mem_we_o}, 0);
    chk(rx_en_o, "R11 rx enable", rx_en_o, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_write(16'h0000, 32'hDEADBEEF);
    do_write(16'hFFFF, 32'h01020304);
    do_read(16'hFFFF);
    do_read(16'h0000);
    do_read(16'h1234);

    // R8 stray bytes while idle
    send_byte(8'h06); send_byte(8'h01); send_byte(8'h15); send_byte(8'h41); send_byte(8'h00);
    check_reply("R8 stray", 0, 0);
    chk(we_cnt == exp_we, "R8 no write", we_cnt, exp_we);
    do_read(16'h0000);

    // R6 stalled write
    send_byte(8'h02); send_byte(8'h00); send_byte(8'h00); send_byte(8'hAA);
    repeat (TMO + 20) @(negedge clk);
    check_reply("R6 nak", 1, 64'h15);
    chk(we_cnt == exp_we, "R6 no write", we_cnt, exp_we);
    do_read(16'h0000);

    // R7 stalled read
    send_byte(8'h05); send_byte(8'h00);
    repeat (TMO + 20) @(negedge clk);
    check_reply("R7 silent", 0, 0);
    do_read(16'hFFFF);

    // R9 echo and stray request during reply
    send_byte(8'h05); send_byte(8'hFF); send_byte(8'hFF);
    while (!drv_en_o) @(negedge clk);
    send_byte(8'h05); send_byte(8'h00); send_byte(8'h00);
    check_reply("R9 echo ignored", 7, {8'h0, 8'h01, 16'hFFFF, exp_word(16'hFFFF)});

    for (int i = 0; i < 60; i++) begin
      logic [15:0] a = {12'h0A0, 4'($urandom)};
      if ($urandom % 2) do_write(a, $urandom);
      else              do_read(a);
    end

    chk(drv_viol == 0, "R10 driver window", drv_viol, 0);
    chk(hold_viol == 0, "R12 byte hold", hold_viol, 0);
    chk(we_cnt == exp_we, "R2 write count", we_cnt, exp_we);
    chk(rxen_viol == 0, "R11 rx enable", rxen_viol, 0);
    report();
    $finish;
  end
endmodule